// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block keeps the control and data words of a row of hardware debug trigger slots and gives them to the rest of a hart through a register-style access port. A requester presents a slot index and raises a read strobe or a write strobe for the slot's control word or its data word. Every write to a control word is legalized before it is stored. Each stored write goes through these steps in turn: the debug-owned lock is checked, the chain/owner pairing with the neighbouring slots is checked, and the owner bit is scrubbed when the hart is not in debug mode. The type field of the written control word then selects the slot's kind: address/data match, interrupt, exception, or disabled.

The block also arbitrates trap-taking hits. Each slot has a hit input from comparison logic outside the block. The block reports the lowest-indexed enabled slot that hits, together with the action code stored in that slot. No hit is reported while the hart is in debug mode.

In an XLEN-bit control word, the type field is bits XLEN-1:XLEN-4. The owner bit (dmode) is bit XLEN-5. The chain bit is bit 11. The action code is bits 15:12 for a match slot and bits 3:0 for an interrupt or exception slot.

Top module: `trig_bank`

## Requirements
- R1: After reset, every slot is disabled. Its control word reads as type 15 with every other bit zero, its data word reads zero, and it never raises a hit.
- R2: Outside debug mode, a write to either word of a slot whose stored dmode is 1 is refused. wr_ok_o is 0 and both of the slot's words keep their values.
- R3: A control-word write to slot i>0 whose written dmode bit is 1 is discarded when slot i-1 has dmode 0 and chain 1. wr_ok_o is 1 and slot i keeps its values.
- R4: For a control-word write whose written dmode bit is 0 and whose type is 2 or 6, the stored chain bit (bit 11) is cleared when slot i+1 has dmode 1.
- R5: Outside debug mode, the dmode bit (XLEN-5) of every stored control word is forced to 0.
- R6: A written type of 2, 4 or 5 stores the legalized word as written. Any other type, 6 included, makes the slot disabled, and it then reads back as 15 in bits XLEN-1:XLEN-4 with every other bit zero.
- R7: A control-word write leaves the slot's data word unchanged. A data-word write that is accepted stores its value unchanged.
- R8: In debug mode hit_valid_o is 0. Otherwise hit_valid_o is set when an enabled slot raises its hit input, and hit_slot_o gives the lowest such index. A disabled slot's hit input is ignored.
- R9: hit_act_o is bits 15:12 of the winning slot's control word when that slot has type 2, and bits 3:0 when it has type 4 or 5.
- R10: An index of N_SLOTS or more reads as zero, and a write to it gives wr_ok_o of 0 and changes no slot.
- R11: When both write strobes are raised in one cycle, only the control-word write is performed and the data word is left unchanged.
- R12: rdata_o, wr_ok_o and the hit outputs follow their inputs in the same cycle. A write becomes visible at the rising clock edge that samples it.

Parameters: N_SLOTS (default 4), XLEN (32 or 64, default 32), IDX_W (index width, default 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| idx_i | input | IDX_W | Slot index for access |
| t1_rd_i | input | 1 | Read strobe for the control word |
| t2_rd_i | input | 1 | Read strobe for the data word |
| t1_wr_i | input | 1 | Write strobe for the control word |
| t2_wr_i | input | 1 | Write strobe for the data word |
| wdata_i | input | XLEN | Write data |
| rdata_o | output | XLEN | Read data for the selected word |
| wr_ok_o | output | 1 | The write in this cycle is accepted |
| trap_hit_i | input | N_SLOTS | Per-slot trap hit from outside |
| hit_valid_o | output | 1 | A slot hit has been selected |
| hit_slot_o | output | IDX_W | Index of the winning slot |
| hit_act_o | output | 4 | Action code of the winning slot |

## Verification
Read data, the write-accepted flag and the hit outputs are combinational, so they are due in the cycle in which the stimulus is applied. The bench drives the inputs on a falling edge and samples these outputs one nanosecond later, well before the next rising edge. Stored contents are due one rising edge after the write strobe. The bench therefore reads the slots back only after the following falling edge, when the strobes have been dropped. The expected values come from a model in the bench that follows the requirements and is updated at the same point in the cycle.

// File: rtl/trig_bank_pkg.sv
package trig_bank_pkg;

   typedef enum logic [1:0] {
      KIND_OFF   = 2'd0,
      KIND_MATCH = 2'd1,
      KIND_IRQ   = 2'd2,
      KIND_EXC   = 2'd3
   } trig_kind_e;

   localparam int          ACT_W     = 4;
   localparam int          CHAIN_BIT = 11;
   localparam int          ACT_M_LSB = 12;
   localparam int          ACT_T_LSB = 0;
   localparam logic [3:0]  TY_MATCH  = 4'd2;
   localparam logic [3:0]  TY_IRQ    = 4'd4;
   localparam logic [3:0]  TY_EXC    = 4'd5;
   localparam logic [3:0]  TY_MATCH6 = 4'd6;
   localparam logic [3:0]  TY_NONE   = 4'd15;

   function automatic trig_kind_e kind_of(input logic [3:0] ty);
      case (ty)
         TY_MATCH: kind_of = KIND_MATCH;
         TY_IRQ:   kind_of = KIND_IRQ;
         TY_EXC:   kind_of = KIND_EXC;
         default:  kind_of = KIND_OFF;
      endcase
   endfunction

endpackage

// File: rtl/trig_slot.sv
module trig_slot
   import trig_bank_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             t1_we_i,
   input  logic             t2_we_i,
   input  trig_kind_e       kind_i,
   input  logic [XLEN-1:0]  wdata_i,
   output logic [XLEN-1:0]  t1_o,
   output logic [XLEN-1:0]  t2_o,
   output logic             dmode_o,
   output logic             chain_o,
   output logic             off_o,
   output logic [ACT_W-1:0] act_o
);
   localparam int DM_BIT = XLEN - 5;

   trig_kind_e      kind_q;
   logic [XLEN-1:0] t1_q;
   logic [XLEN-1:0] t2_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         kind_q <= KIND_OFF;
         t1_q   <= '0;
         t2_q   <= '0;
      end else begin
         if (t1_we_i) begin
            kind_q <= kind_i;
            t1_q   <= (kind_i == KIND_OFF) ? '0 : wdata_i;
         end
         if (t2_we_i) t2_q <= wdata_i;
      end
   end

   always_comb begin
      t1_o    = (kind_q == KIND_OFF) ? {TY_NONE, {(XLEN-4){1'b0}}} : t1_q;
      t2_o    = t2_q;
      off_o   = (kind_q == KIND_OFF);
      dmode_o = (kind_q != KIND_OFF) & t1_q[DM_BIT];
      chain_o = (kind_q == KIND_MATCH) & t1_q[CHAIN_BIT];
      case (kind_q)
         KIND_MATCH:        act_o = t1_q[ACT_M_LSB +: ACT_W];
         KIND_IRQ, KIND_EXC: act_o = t1_q[ACT_T_LSB +: ACT_W];
         default:           act_o = '0;
      endcase
   end

   // R1: a fresh slot is disabled with an empty data word
   p_reset_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (off_o && t2_o == '0));

   // R7: a control-word-only write does not disturb the data word
   p_t2_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (t1_we_i && !t2_we_i) |=> $stable(t2_o));

endmodule

// File: rtl/trig_legalize.sv
module trig_legalize
   import trig_bank_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            dbg_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic            cur_dmode_i,
   input  logic            prev_dmode_i,
   input  logic            prev_chain_i,
   input  logic            next_dmode_i,
   output logic            locked_o,
   output logic            drop_o,
   output logic [XLEN-1:0] legal_o,
   output trig_kind_e      kind_o
);
   localparam int DM_BIT = XLEN - 5;

   logic [3:0] ty;

   always_comb begin
      ty       = wdata_i[XLEN-1 -: 4];
      locked_o = cur_dmode_i & ~dbg_i;
      drop_o   = ~prev_dmode_i & prev_chain_i & wdata_i[DM_BIT];
      legal_o  = wdata_i;
      if (next_dmode_i && !wdata_i[DM_BIT] && (ty == TY_MATCH || ty == TY_MATCH6))
         legal_o[CHAIN_BIT] = 1'b0;
      if (!dbg_i)
         legal_o[DM_BIT] = 1'b0;
      kind_o   = kind_of(ty);
   end

endmodule

// File: rtl/trig_hit_pick.sv
module trig_hit_pick
   import trig_bank_pkg::*;
#(
   parameter int N_SLOTS = 4,
   parameter int SEL_W   = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     dbg_i,
   input  logic [N_SLOTS-1:0]       hit_i,
   input  logic [N_SLOTS*ACT_W-1:0] act_i,
   output logic                     valid_o,
   output logic [SEL_W-1:0]         slot_o,
   output logic [ACT_W-1:0]         act_o
);
   always_comb begin
      slot_o = '0;
      act_o  = '0;
      for (int i = N_SLOTS - 1; i >= 0; i--) begin
         if (hit_i[i]) begin
            slot_o = SEL_W'(i);
            act_o  = act_i[i*ACT_W +: ACT_W];
         end
      end
      valid_o = ~dbg_i & (|hit_i);
   end

   // R8: never a hit in debug mode
   p_no_hit_dbg_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dbg_i |-> !valid_o);

   // R8: the reported slot really is hitting
   p_winner_hits_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> hit_i[slot_o]);

endmodule

// File: rtl/trig_bank.sv
module trig_bank
   import trig_bank_pkg::*;
#(
   parameter int N_SLOTS = 4,
   parameter int XLEN    = 32,
   parameter int IDX_W   = 3
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               dbg_mode_i,
   input  logic [IDX_W-1:0]   idx_i,
   input  logic               t1_rd_i,
   input  logic               t2_rd_i,
   input  logic               t1_wr_i,
   input  logic               t2_wr_i,
   input  logic [XLEN-1:0]    wdata_i,
   output logic [XLEN-1:0]    rdata_o,
   output logic               wr_ok_o,
   input  logic [N_SLOTS-1:0] trap_hit_i,
   output logic               hit_valid_o,
   output logic [IDX_W-1:0]   hit_slot_o,
   output logic [3:0]         hit_act_o
);
   localparam int             SEL_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
   localparam int             DM_BIT = XLEN - 5;
   localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(N_SLOTS);

   if (N_SLOTS < 1) begin : g_bad_n
      $error("trig_bank: N_SLOTS must be at least 1");
   end
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("trig_bank: XLEN must be 32 or 64");
   end
   if (IDX_W < SEL_W) begin : g_bad_idx
      $error("trig_bank: IDX_W too narrow for N_SLOTS");
   end

   logic [N_SLOTS-1:0]       dmode_v, chain_v, off_v, t1_we_v, t2_we_v;
   logic [XLEN-1:0]          t1_v [N_SLOTS];
   logic [XLEN-1:0]          t2_v [N_SLOTS];
   logic [N_SLOTS*ACT_W-1:0] act_v;

   logic             in_range;
   logic [SEL_W-1:0] sel;
   logic             cur_dm, prev_dm, prev_ch, next_dm;
   logic             locked, drop;
   logic [XLEN-1:0]  legal;
   trig_kind_e       new_kind;
   logic             do_t1, do_t2;

   always_comb begin
      in_range = ({1'b0, idx_i} < N_LIM);
      sel      = in_range ? idx_i[SEL_W-1:0] : '0;
      cur_dm   = in_range & dmode_v[sel];
      prev_dm  = 1'b0;
      prev_ch  = 1'b0;
      next_dm  = 1'b0;
      if (sel != '0) begin
         prev_dm = dmode_v[sel - 1'b1];
         prev_ch = chain_v[sel - 1'b1];
      end
      if (int'(sel) + 1 < N_SLOTS)
         next_dm = dmode_v[sel + 1'b1];
   end

   trig_legalize #(.XLEN(XLEN)) i_legal (
      .dbg_i        (dbg_mode_i),
      .wdata_i      (wdata_i),
      .cur_dmode_i  (cur_dm),
      .prev_dmode_i (prev_dm),
      .prev_chain_i (prev_ch),
      .next_dmode_i (next_dm),
      .locked_o     (locked),
      .drop_o       (drop),
      .legal_o      (legal),
      .kind_o       (new_kind)
   );

   always_comb begin
      do_t1   = t1_wr_i & in_range & ~locked & ~drop;
      do_t2   = t2_wr_i & ~t1_wr_i & in_range & ~locked;
      wr_ok_o = (t1_wr_i | t2_wr_i) & in_range & ~locked;
      rdata_o = '0;
      if (in_range) begin
         if (t1_rd_i)      rdata_o = t1_v[sel];
         else if (t2_rd_i) rdata_o = t2_v[sel];
      end
   end

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      assign t1_we_v[g] = do_t1 & (sel == SEL_W'(g));
      assign t2_we_v[g] = do_t2 & (sel == SEL_W'(g));

      trig_slot #(.XLEN(XLEN)) i_slot (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .t1_we_i (t1_we_v[g]),
         .t2_we_i (t2_we_v[g]),
         .kind_i  (new_kind),
         .wdata_i (t1_we_v[g] ? legal : wdata_i),
         .t1_o    (t1_v[g]),
         .t2_o    (t2_v[g]),
         .dmode_o (dmode_v[g]),
         .chain_o (chain_v[g]),
         .off_o   (off_v[g]),
         .act_o   (act_v[g*ACT_W +: ACT_W])
      );
   end

   logic [SEL_W-1:0] win;

   trig_hit_pick #(.N_SLOTS(N_SLOTS), .SEL_W(SEL_W)) i_pick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .dbg_i   (dbg_mode_i),
      .hit_i   (trap_hit_i & ~off_v),
      .act_i   (act_v),
      .valid_o (hit_valid_o),
      .slot_o  (win),
      .act_o   (hit_act_o)
   );

   assign hit_slot_o = IDX_W'(win);

   // R2: a locked slot is never written outside debug mode
   p_locked_refused_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cur_dm && !dbg_mode_i && (t1_wr_i || t2_wr_i)) |-> (!wr_ok_o && t1_we_v == '0 && t2_we_v == '0));

   // R3: a discarded owner write is reported accepted but stores nothing
   p_drop_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (t1_wr_i && drop && !locked && in_range) |-> (wr_ok_o && t1_we_v == '0));

   // R5: nothing outside debug mode stores an owner bit
   p_no_dm_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (t1_we_v != '0 && !dbg_mode_i) |=> $stable(dmode_v));

   // R10: out-of-range index is inert
   p_bad_idx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_range |-> (!wr_ok_o && rdata_o == '0 && t1_we_v == '0 && t2_we_v == '0));

   // R11: control word wins when both strobes are raised
   p_both_t1_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (t1_wr_i && t2_wr_i) |-> (t2_we_v == '0));

   // R8: a hit is reported on the lowest enabled slot only
   p_hit_enabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_valid_o |-> (!off_v[win] && trap_hit_i[win]));

   initial begin
      assert (DM_BIT > ACT_M_LSB + ACT_W - 1);
   end

endmodule

// File: tb/test_trig_bank.sv
module test_trig_bank;
   localparam int N  = 4;
   localparam int XL = 32;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dbg = 1'b0;
   logic [IW-1:0] idx = '0;
   logic          t1_rd = 0, t2_rd = 0, t1_wr = 0, t2_wr = 0;
   logic [XL-1:0] wdata = '0;
   logic [XL-1:0] rdata;
   logic          wr_ok;
   logic [N-1:0]  hits = '0;
   logic          hv;
   logic [IW-1:0] hslot;
   logic [3:0]    hact;

   int n_chk = 0;
   int n_fail = 0;

   logic [XL-1:0] m_t1 [N];
   logic [XL-1:0] m_t2 [N];

   always #5 clk = ~clk;

   trig_bank #(.N_SLOTS(N), .XLEN(XL), .IDX_W(IW)) i_trig_bank (
      .clk_i(clk), .rst_ni(rst_n), .dbg_mode_i(dbg), .idx_i(idx),
      .t1_rd_i(t1_rd), .t2_rd_i(t2_rd), .t1_wr_i(t1_wr), .t2_wr_i(t2_wr),
      .wdata_i(wdata), .rdata_o(rdata), .wr_ok_o(wr_ok), .trap_hit_i(hits),
      .hit_valid_o(hv), .hit_slot_o(hslot), .hit_act_o(hact)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic m_dm(input int i);
      return m_t1[i][27];
   endfunction

   function automatic logic m_ch(input int i);
      return (m_t1[i][31:28] == 4'd2) && m_t1[i][11];
   endfunction

   // mode: 1 control, 2 data, 3 both
   task automatic m_wr(input int i, input logic [31:0] v, input int mode,
                       input logic d, output logic ok);
      logic [31:0] nv;
      logic [3:0]  t;
      ok = 1'b0;
      if (i >= N) return;
      if (m_dm(i) && !d) return;
      ok = 1'b1;
      if (mode == 2) begin
         m_t2[i] = v;
         return;
      end
      if (i > 0 && !m_dm(i-1) && m_ch(i-1) && v[27]) return;
      t  = v[31:28];
      nv = v;
      if (i < N-1 && m_dm(i+1) && !v[27] && (t == 4'd2 || t == 4'd6)) nv[11] = 1'b0;
      if (!d) nv[27] = 1'b0;
      if (t == 4'd2 || t == 4'd4 || t == 4'd5) m_t1[i] = nv;
      else m_t1[i] = 32'hF000_0000;
   endtask

   task automatic wr(input string req, input int i, input logic [31:0] v,
                     input int mode, input logic d);
      logic ok;
      @(negedge clk);
      idx = IW'(i); wdata = v; dbg = d;
      t1_wr = (mode != 2); t2_wr = (mode != 1);
      #1;
      m_wr(i, v, mode, d, ok);
      chk(req, {63'd0, wr_ok}, {63'd0, ok});
      @(negedge clk);
      t1_wr = 0; t2_wr = 0;
   endtask

   task automatic rd(input string req, input int i, input bit second, input logic [31:0] exp);
      @(negedge clk);
      idx = IW'(i); t1_rd = !second; t2_rd = second;
      #1;
      chk(req, {32'd0, rdata}, {32'd0, exp});
      t1_rd = 0; t2_rd = 0;
   endtask

   task automatic rd_all(input string req);
      for (int i = 0; i < N; i++) begin
         rd(req, i, 1'b0, m_t1[i]);
         rd(req, i, 1'b1, m_t2[i]);
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_t1[i] = 32'hF000_0000;
         m_t2[i] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: reset contents and no hits
      rd_all("R1");
      @(negedge clk); hits = '1; #1;
      chk("R1", {63'd0, hv}, 64'd0);
      hits = '0;

      // R10: indices past the bank
      for (int i = N; i < (1 << IW); i++) begin
         wr("R10", i, 32'h2000_1000, 1, 1'b1);
         wr("R10", i, 32'h1234_5678, 2, 1'b1);
         rd("R10", i, 1'b0, 32'h0);
         rd("R10", i, 1'b1, 32'h0);
      end
      rd_all("R10");

      // R5 R6 R7: type sweep outside debug mode
      for (int s = 0; s < N; s++) begin
         for (int t = 0; t < 16; t++) begin
            wr("R7", s, {4'(t), 4'(s), 24'h3C_C3C3}, 2, 1'b0);
            wr("R6", s, {4'(t), 28'hA5A_5A5A}, 1, 1'b0);
            rd("R6 R5", s, 1'b0, m_t1[s]);
            rd("R7", s, 1'b1, m_t2[s]);
         end
      end

      // R4: owner set on slot 3, chain on slot 2 cleared
      wr("R4", 3, 32'h2800_0805, 1, 1'b1);
      wr("R4", 2, 32'h2000_7801, 1, 1'b1);
      rd("R4", 2, 1'b0, 32'h2000_7001);
      wr("R4", 2, 32'h6000_0800, 1, 1'b1);
      rd("R4", 2, 1'b0, 32'hF000_0000);

      // R2: locked slot 3 outside debug mode
      wr("R2", 3, 32'h4000_0001, 1, 1'b0);
      wr("R2", 3, 32'hDEAD_BEEF, 2, 1'b0);
      wr("R2", 3, 32'h4000_0001, 3, 1'b0);
      rd_all("R2");
      wr("R2", 3, 32'hCAFE_0001, 2, 1'b1);
      rd("R2", 3, 1'b1, 32'hCAFE_0001);

      // R3: chained predecessor blocks owner bit
      wr("R3", 0, 32'h2000_0800, 1, 1'b1);
      wr("R3", 1, 32'h4800_0003, 1, 1'b1);
      rd("R3", 1, 1'b0, m_t1[1]);
      wr("R3", 1, 32'h4000_0003, 1, 1'b1);
      rd("R3", 1, 1'b0, 32'h4000_0003);

      // R11: both strobes
      wr("R11", 1, 32'h5000_0002, 3, 1'b1);
      rd("R11", 1, 1'b0, 32'h5000_0002);
      rd("R11", 1, 1'b1, m_t2[1]);

      // R8 R9: hit arbitration sweep
      wr("R8", 0, 32'hF000_0000, 1, 1'b1);
      wr("R9", 1, 32'h4000_0009, 1, 1'b1);
      wr("R9", 2, 32'h2000_6000, 1, 1'b1);
      wr("R9", 3, 32'h5000_000C, 1, 1'b1);
      rd_all("R12");
      for (int d = 0; d < 2; d++) begin
         for (int h = 0; h < 16; h++) begin
            logic       ev;
            logic [2:0] es;
            logic [3:0] ea;
            ev = 1'b0; es = '0; ea = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (h[i] && m_t1[i][31:28] != 4'hF) begin
                  ev = 1'b1;
                  es = 3'(i);
                  ea = (m_t1[i][31:28] == 4'd2) ? m_t1[i][15:12] : m_t1[i][3:0];
               end
            end
            if (d == 1) ev = 1'b0;
            @(negedge clk);
            dbg = d[0]; hits = 4'(h);
            #1;
            chk("R8", {63'd0, hv}, {63'd0, ev});
            if (ev) begin
               chk("R8", {61'd0, hslot}, {61'd0, es});
               chk("R9", {60'd0, hact}, {60'd0, ea});
            end
         end
      end
      hits = '0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule